// File: doc/BRIEF.md
# Pattern-Register Segmented Float Reducer

This unit reduces a vector of 32-bit IEEE-754 single-precision lanes segment by segment. The segment layout is not part of each reduce command. It sits in a per-lane boundary register that a separate set-pattern command loads. Any number of later max, min or add commands then read that register, so one programmed layout serves a whole series of reductions without being written again.

A reduce walks the lanes in ascending order. It keeps one running accumulator, which restarts from the lane value at every lane flagged as the first of a segment. When the walk ends, each lane of the result carries the final value of the segment it belongs to. Commands arrive on a valid/ready stream. A command transfers on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` drops once a reduce is taken and stays low until that reduce's result has been taken. Results leave on a second valid/ready stream. While `res_valid_o` is high and `res_ready_i` is low, the result waits with its data frozen. An unknown opcode is consumed and reported on a plain one-cycle error pin.

Top module: `segred_unit`

## Requirements
- R1: `cmd_ready_o` is high whenever no reduce is in flight and no result is waiting. It is low from the edge that accepts a reduce until the edge where the result is taken.
- R2: An opcode is a reduce when (opcode − 0xFA), taken as an unsigned 8-bit value, is below 3: 0xFA is max, 0xFB is min, 0xFC is add. The result becomes valid exactly LANES clock edges after the accepting edge.
- R3: Opcode 0x8C is set-pattern. For each lane k ≥ 1, bit 0 of lane k's 32-bit operand word (bits 32k) set to 1 makes lane k the first lane of a new segment. Lane 0 always starts a segment. Set-pattern produces no result and no error.
- R4: The boundary register changes only on an accepted set-pattern. Successive reduces reuse the stored layout.
- R5: After reset the boundary register holds a single segment covering all lanes.
- R6: Add sums a segment in ascending lane order, rounding each step to nearest-even in single precision. An exact cancellation gives +0. Every lane of the segment outputs the segment's final sum.
- R7: Max and min place the largest or smallest value of the segment on every lane of the segment. Ordering is numeric, with −0 below +0.
- R8: Any other opcode is accepted and raises `err_o` for exactly the one cycle after the accepting edge. It produces no result and leaves the boundary register unchanged.
- R9: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o` stays high and `res_vec_o` stays stable.
- R10: During and right after reset, `cmd_ready_o` is 1, `res_valid_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Unit can take a command |
| cmd_op_i | input | 8 | Opcode |
| cmd_vec_i | input | LANES*32 | Vector operand, lane k at bits 32k+31:32k |
| res_valid_o | output | 1 | Result vector offered |
| res_ready_i | input | 1 | Consumer takes the result |
| res_vec_o | output | LANES*32 | Reduced vector, lane k at bits 32k+31:32k |
| err_o | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
A reduce result is due exactly LANES edges after the accepting edge. The bench counts falling edges from the one that follows acceptance and requires the LANES-th to be the first where `res_valid_o` is seen high. Only after that does it compare the lanes. The error pulse is due on the one cycle after acceptance and must be gone one cycle later, while set-pattern must leave `res_valid_o` low on both of those cycles. All inputs change on falling edges and all outputs are sampled there, half a period away from the edge that moves them.

// File: rtl/segred_pkg.sv
package segred_pkg;
  localparam int FW = 32;
  localparam logic [7:0] OP_SETPAT   = 8'h8C;
  localparam logic [7:0] OP_RED_BASE = 8'hFA;
  localparam logic [7:0] OP_RED_CNT  = 8'd3;

  typedef enum logic [1:0] {
    RK_MAX = 2'd0,
    RK_MIN = 2'd1,
    RK_ADD = 2'd2
  } red_kind_e;
endpackage

// File: rtl/sr_fp_add.sv
module sr_fp_add (
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  output logic [31:0] y_o
);
  logic        sa, sb, swap, bs, ls;
  logic [7:0]  ea, eb, be, le, d;
  logic [23:0] ma, mb, bm, lm;
  logic [26:0] lext, sh, m;
  logic [27:0] s;
  logic [24:0] r;
  logic        st, up;
  int          e, p;

  always_comb begin
    sa = a_i[31]; ea = a_i[30:23];
    sb = b_i[31]; eb = b_i[30:23];
    ma = (ea == 8'd0) ? 24'd0 : {1'b1, a_i[22:0]};
    mb = (eb == 8'd0) ? 24'd0 : {1'b1, b_i[22:0]};
    swap = {eb, mb} > {ea, ma};
    bs = swap ? sb : sa;  be = swap ? eb : ea;  bm = swap ? mb : ma;
    ls = swap ? sa : sb;  le = swap ? ea : eb;  lm = swap ? ma : mb;
    d = be - le;
    lext = {lm, 3'b000};
    if (d >= 8'd27) begin
      sh = 27'd0;
      st = |lm;
    end else begin
      sh = lext >> d;
      st = |(lext & ((27'd1 << d) - 27'd1));
    end
    sh[0] = sh[0] | st;
    s = (bs == ls) ? ({1'b0, bm, 3'b000} + {1'b0, sh})
                   : ({1'b0, bm, 3'b000} - {1'b0, sh});
    e = int'(be);
    p = 0;
    m = 27'd0;
    r = 25'd0;
    up = 1'b0;
    if (s[27]) begin
      m = s[27:1] | {26'd0, s[0]};
      e = e + 1;
    end else begin
      for (int i = 0; i < 27; i++) if (s[i]) p = i;
      m = s[26:0] << (26 - p);
      e = e - (26 - p);
    end
    up = m[2] & (m[1] | m[0] | m[3]);
    r = {1'b0, m[26:3]} + {24'd0, up};
    if (r[24]) begin
      r = r >> 1;
      e = e + 1;
    end
    if (s == 28'd0 || !(r[23] | r[24])) y_o = 32'd0;
    else if (e <= 0) y_o = {bs, 31'd0};
    else if (e >= 255) y_o = {bs, 8'hFF, 23'd0};
    else y_o = {bs, e[7:0], r[22:0]};
    if (ea == 8'hFF || eb == 8'hFF) begin
      if ((ea == 8'hFF && a_i[22:0] != 23'd0) || (eb == 8'hFF && b_i[22:0] != 23'd0) ||
          (ea == 8'hFF && eb == 8'hFF && sa != sb))
        y_o = 32'h7FC0_0000;
      else if (ea == 8'hFF) y_o = a_i;
      else y_o = b_i;
    end
  end
endmodule

// File: rtl/sr_lane_alu.sv
module sr_lane_alu
  import segred_pkg::*;
(
  input  red_kind_e         kind_i,
  input  logic [FW-1:0]     acc_i,
  input  logic [FW-1:0]     x_i,
  output logic [FW-1:0]     y_o
);
  logic [FW-1:0] sum;
  logic [FW-1:0] ka, kx;
  logic          x_above;

  sr_fp_add u_add (.a_i(acc_i), .b_i(x_i), .y_o(sum));

  // Map sign-magnitude floats onto an unsigned order key.
  assign ka = acc_i[FW-1] ? ~acc_i : {1'b1, acc_i[FW-2:0]};
  assign kx = x_i[FW-1]   ? ~x_i   : {1'b1, x_i[FW-2:0]};
  assign x_above = kx > ka;

  always_comb begin
    unique case (kind_i)
      RK_MAX:  y_o = x_above ? x_i : acc_i;
      RK_MIN:  y_o = x_above ? acc_i : x_i;
      default: y_o = sum;
    endcase
  end
endmodule

// File: rtl/sr_seg_bcast.sv
module sr_seg_bcast
  import segred_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]    start_i,
  input  logic [LANES*FW-1:0] pre_i,
  output logic [LANES*FW-1:0] out_o
);
  logic [FW-1:0] seg_v [LANES];

  // Each lane takes the prefix at the last lane of its segment.
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    if (j == LANES - 1) begin : g_tail
      assign seg_v[j] = pre_i[j*FW +: FW];
    end else begin : g_body
      assign seg_v[j] = start_i[j+1] ? pre_i[j*FW +: FW] : seg_v[j+1];
    end
    assign out_o[j*FW +: FW] = seg_v[j];
  end
endmodule

// File: rtl/segred_unit.sv
module segred_unit
  import segred_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [7:0]          cmd_op_i,
  input  logic [LANES*FW-1:0] cmd_vec_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [LANES*FW-1:0] res_vec_o,
  output logic                err_o
);
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IW-1:0] LAST = IW'(LANES - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;

  st_e             state;
  logic [IW-1:0]   idx;
  red_kind_e       kind_q;
  logic [LANES-1:0] pat_q;
  logic [FW-1:0]   data_q [LANES];
  logic [FW-1:0]   pre_q  [LANES];
  logic [FW-1:0]   acc_q, alu_y, nxt;
  logic [LANES*FW-1:0] pre_flat;
  logic            err_q;
  logic            accept, is_red, is_set;
  logic [7:0]      rel;

  assign cmd_ready_o = (state == S_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign rel         = cmd_op_i - OP_RED_BASE;
  assign is_red      = rel < OP_RED_CNT;
  assign is_set      = cmd_op_i == OP_SETPAT;
  assign res_valid_o = (state == S_DONE);
  assign err_o       = err_q;

  sr_lane_alu u_alu (.kind_i(kind_q), .acc_i(acc_q), .x_i(data_q[idx]), .y_o(alu_y));

  assign nxt = pat_q[idx] ? data_q[idx] : alu_y;

  for (genvar k = 0; k < LANES; k++) begin : g_flat
    assign pre_flat[k*FW +: FW] = pre_q[k];
  end

  sr_seg_bcast #(.LANES(LANES)) u_bcast (.start_i(pat_q), .pre_i(pre_flat), .out_o(res_vec_o));

  // Boundary register: lane 0 always opens a segment.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= LANES'(1);
      err_q <= 1'b0;
    end else begin
      err_q <= accept && !is_red && !is_set;
      if (accept && is_set)
        for (int k = 0; k < LANES; k++) pat_q[k] <= (k == 0) ? 1'b1 : cmd_vec_i[k*FW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      kind_q <= RK_ADD;
      acc_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept && is_red) begin
          state  <= S_RUN;
          idx    <= '0;
          kind_q <= red_kind_e'(rel[1:0]);
        end
        S_RUN: begin
          acc_q <= nxt;
          idx   <= idx + IW'(1);
          if (idx == LAST) state <= S_DONE;
        end
        default: if (res_ready_i) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && is_red)
      for (int k = 0; k < LANES; k++) data_q[k] <= cmd_vec_i[k*FW +: FW];
    if (state == S_RUN) pre_q[idx] <= nxt;
  end

  // R1: taking a reduce closes the command port
  p_busy_after_reduce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_red) |=> (!cmd_ready_o && !res_valid_o));

  // R3: set-pattern produces no result
  p_setpat_no_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_set) |=> (!res_valid_o && cmd_ready_o && !err_o));

  // R4: boundaries move only on set-pattern
  p_pattern_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && is_set) |=> $stable(pat_q));

  // R8: error pulse never coincides with a result
  p_err_no_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!res_valid_o && cmd_ready_o));

  // R9: a stalled result holds
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_vec_o)));
endmodule

// File: tb/segred_unit_bench.sv
`timescale 1ns/1ps
module segred_unit_bench;
  localparam int LN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_op = 8'h00;
  logic [LN*32-1:0] cmd_vec = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [LN*32-1:0] res_vec;
  logic err;

  logic [31:0] vin   [LN];
  logic [31:0] exp_v [LN];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  segred_unit #(.LANES(LN)) u_segred_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_vec_i(cmd_vec), .res_valid_o(res_valid),
    .res_ready_i(res_ready), .res_vec_o(res_vec), .err_o(err));

  function automatic logic [31:0] i2f(int v);
    int mg;
    int msb;
    if (v == 0) return 32'd0;
    mg = (v < 0) ? -v : v;
    msb = 0;
    for (int i = 0; i < 31; i++) if (mg[i]) msb = i;
    return {v < 0, 8'(127 + msb), 23'((mg << (23 - msb)) & 32'h7F_FFFF)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic issue(logic [7:0] op);
    @(negedge clk);
    cmd_op = op;
    for (int k = 0; k < LN; k++) cmd_vec[k*32 +: 32] = vin[k];
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get_result(string req);
    int n = 0;
    while (!res_valid && n < LN + 4) begin
      @(negedge clk);
      n++;
    end
    chk("R2", "latency", 32'(n), 32'(LN));
    for (int k = 0; k < LN; k++)
      chk(req, $sformatf("lane%0d", k), res_vec[k*32 +: 32], exp_v[k]);
    @(negedge clk);
  endtask

  task automatic set_pat(logic [LN-1:0] starts);
    for (int k = 0; k < LN; k++) vin[k] = {31'd0, starts[k]};
    issue(8'h8C);
    chk("R3", "setpat no result", 32'(res_valid), 32'd0);
    chk("R3", "setpat no error", 32'(err), 32'd0);
    @(negedge clk);
    chk("R3", "setpat no result later", 32'(res_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R10", "ready", 32'(cmd_ready), 32'd1);
    chk("R10", "res_valid", 32'(res_valid), 32'd0);
    chk("R10", "err", 32'(err), 32'd0);
  endtask

  task automatic t_default_single();
    for (int k = 0; k < LN; k++) begin vin[k] = i2f(k + 1); exp_v[k] = i2f(36); end
    issue(8'hFC);
    chk("R1", "ready low while busy", 32'(cmd_ready), 32'd0);
    get_result("R5");
    chk("R1", "ready back", 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_add_segments();
    set_pat(8'b0010_1000);
    for (int k = 0; k < LN; k++) vin[k] = i2f(k + 1);
    for (int k = 0; k < LN; k++) exp_v[k] = (k < 3) ? i2f(6) : (k < 5) ? i2f(9) : i2f(21);
    issue(8'hFC);
    get_result("R6");
  endtask

  task automatic t_max_min_shared();
    int v [LN] = '{-3, 7, 2, -5, -1, 4, 9, 0};
    for (int k = 0; k < LN; k++) vin[k] = i2f(v[k]);
    for (int k = 0; k < LN; k++) exp_v[k] = (k < 3) ? i2f(7) : (k < 5) ? i2f(-1) : i2f(9);
    issue(8'hFA);
    get_result("R7");
    for (int k = 0; k < LN; k++) vin[k] = i2f(v[k]);
    for (int k = 0; k < LN; k++) exp_v[k] = (k < 3) ? i2f(-3) : (k < 5) ? i2f(-5) : i2f(0);
    issue(8'hFB);
    get_result("R4");
  endtask

  task automatic t_invalid();
    logic [7:0] bad [3] = '{8'h10, 8'hFD, 8'hF9};
    foreach (bad[b]) begin
      for (int k = 0; k < LN; k++) vin[k] = 32'd1;
      issue(bad[b]);
      chk("R8", "err pulse", 32'(err), 32'd1);
      chk("R8", "no result", 32'(res_valid), 32'd0);
      @(negedge clk);
      chk("R8", "err cleared", 32'(err), 32'd0);
      chk("R8", "still no result", 32'(res_valid), 32'd0);
    end
    for (int k = 0; k < LN; k++) vin[k] = i2f(k + 1);
    for (int k = 0; k < LN; k++) exp_v[k] = (k < 3) ? i2f(6) : (k < 5) ? i2f(9) : i2f(21);
    issue(8'hFC);
    get_result("R8");
  endtask

  task automatic t_round_order();
    set_pat('0);
    vin[0] = i2f(1);
    for (int k = 1; k < LN; k++) vin[k] = 32'h3380_0000;
    for (int k = 0; k < LN; k++) exp_v[k] = 32'h3F80_0000;
    issue(8'hFC);
    get_result("R6");
  endtask

  task automatic t_cancel();
    set_pat(8'b0101_0100);
    vin[0] = i2f(3);       vin[1] = i2f(-1);
    vin[2] = 32'h3FC0_0000; vin[3] = 32'hBFC0_0000;
    vin[4] = i2f(-2);      vin[5] = i2f(-6);
    vin[6] = i2f(5);       vin[7] = 32'd0;
    exp_v[0] = i2f(2);  exp_v[1] = i2f(2);
    exp_v[2] = 32'd0;   exp_v[3] = 32'd0;
    exp_v[4] = i2f(-8); exp_v[5] = i2f(-8);
    exp_v[6] = i2f(5);  exp_v[7] = i2f(5);
    issue(8'hFC);
    get_result("R6");
  endtask

  task automatic t_backpressure();
    logic [LN*32-1:0] first;
    for (int k = 0; k < LN; k++) vin[k] = i2f(2 * k);
    res_ready = 1'b0;
    issue(8'hFA);
    repeat (LN) @(negedge clk);
    chk("R9", "valid under stall", 32'(res_valid), 32'd1);
    first = res_vec;
    repeat (3) @(negedge clk);
    chk("R9", "still valid", 32'(res_valid), 32'd1);
    chk("R9", "data stable", 32'(res_vec == first), 32'd1);
    chk("R9", "lane0 max", res_vec[31:0], i2f(2));
    chk("R1", "ready low while held", 32'(cmd_ready), 32'd0);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R9", "taken", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_single();
    t_add_segments();
    t_max_min_shared();
    t_invalid();
    t_round_order();
    t_cancel();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule